// File: doc/BRIEF.md
# Programmable External Memory Strobe Generator

This block turns one request for an external memory access into the chip-enable, output-enable and per-byte write-strobe waveforms that the memory needs. Every edge is placed at a programmable offset, counted in phases. One phase is one period of `clk`, and one memory cycle is two phases, so the block runs from a clock at twice the memory cycle rate. The offsets and the other timing settings come from a 32-bit configuration word for each bank. The word of the selected bank is copied when the request is accepted.

A requester offers a bank number, a read/write flag, an address and write data, using a valid/ready handshake. The block then runs the access, drives the address and write data, and returns a one-clock `done` pulse together with the read data. An optional wait input can stretch the access. The data bus drive can be held back at the start of a write. After each access the bus stays idle for a programmable release time. A request offered during that time is accepted and held until the release time ends.

Configuration word fields, from bit 0 upward:

| Bits | Meaning |
|------|---------|
| [3:0] | Access length in memory cycles. The access lasts twice this many phases; 0 is treated as 1. |
| [5:4] | Release time in memory cycles (0 to 3). |
| [6] | Bank width: 1 = 16 bits, 0 = 8 bits. |
| [7] | Wait-input enable. |
| [11:8] | Chip-enable fall offset from the start of the access. |
| [15:12] | Chip-enable rise lead before the end of the access. |
| [19:16] | Output-enable fall offset from the start of the access. |
| [23:20] | Write-strobe fall offset from the start of the access. |
| [27:24] | Write-strobe rise lead before the end of the access. |
| [31:28] | Data drive delay from the start of a write. |

All offsets, leads and delays are in phases.

Top module: `memstrobe_gen`

## Requirements
- R1: After reset and while no access runs, `mem_ce_n`, `mem_oe_n` and every `mem_we_n` bit are 1, `mem_dq_oe` and `done` are 0, and `req_ready` is 1.
- R2: An access whose length field is L (L > 0) occupies phases 0 to 2L-1, where phase 0 is the first clock after the accepting edge. `done` is 1 for exactly one clock, at phase 2L, and `rdata` is valid from that clock on.
- R3: `mem_ce_n` is 0 in the phases p that satisfy p >= chip-enable fall offset and p < end - chip-enable rise lead. Here "end" is the phase in which `done` is 1.
- R4: On a read, `mem_oe_n` is 0 from the phase equal to the output-enable fall offset until the end of the access. It stays 1 for the whole of a write, and is never 0 while any `mem_we_n` bit is 0.
- R5: On a write, the enabled `mem_we_n` bits are 0 in the phases p that satisfy p >= write-strobe fall offset and p < end - write-strobe rise lead. They stay 1 on reads.
- R6: On a write, `mem_dq_oe` is 1 from the phase equal to the drive delay until the end of the access, with `mem_dq_out` equal to the request's write data. It stays 0 on reads.
- R7: With the wait enable bit set, each phase in which `mem_wait` is 1 adds one phase to the access. The rise of chip-enable and of the write strobe moves with the new end. With the bit clear, `mem_wait` has no effect.
- R8: After the end of an access the block waits 2R phases, where R is the release field, before a new access can start. `req_ready` is 0 during an access and during a release with a request already held. A request accepted during the release starts in the phase right after the release ends. With R = 0, the access goes straight back to idle.
- R9: On an 8-bit bank only `mem_we_n[0]` is driven and `rdata[15:8]` is 0. On a 16-bit bank all byte strobes are driven and the whole bus is captured.
- R10: The configuration word fields sit at the bit positions given in the table above. Bank b's word is `bank_cfg[32*b +: 32]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, two per memory cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_cfg | input | NUM_BANKS*32 | Configuration words, bank 0 in the low word |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this clock |
| req_bank | input | BANK_W | Bank selected for the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-clock pulse at the end of the access |
| rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Address toward the memory |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data returned by the memory |
| mem_wait | input | 1 | External wait request |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | DATA_W/8 | Byte write strobes, active low |

## Verification
Four bank settings are used. Reads and writes on 16-bit banks with different offsets and leads show whether each edge is placed from its own field, and whether start offsets and end leads are told apart. An 8-bit bank shows whether the upper byte is masked and the upper strobe held off. The same wait burst is applied to a bank with the wait enable set and to one with it clear, which shows both that the access stretches and that the input is gated. Back-to-back requests, offered with and without a release time, show the hold during release and the exact start phase of the second access.

// File: rtl/memstrobe_pkg.sv
`timescale 1ns/1ps
package memstrobe_pkg;

   localparam int CFG_W  = 32;
   localparam int PCNT_W = 8;
   localparam int REM_W  = 6;
   localparam int RC_W   = 4;

   typedef struct packed {
      logic [3:0] drv_dly;
      logic [3:0] we_lead;
      logic [3:0] we_fall;
      logic [3:0] oe_fall;
      logic [3:0] ce_lead;
      logic [3:0] ce_fall;
      logic       wait_en;
      logic       wide;
      logic [1:0] rel_cyc;
      logic [3:0] len_cyc;
   } bank_cfg_t;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ACCESS  = 2'd1,
      ST_RELEASE = 2'd2
   } seq_state_t;

   function automatic logic [REM_W-1:0] access_phases(input bank_cfg_t c);
      logic [REM_W-1:0] cyc;
      cyc = (c.len_cyc == 4'd0) ? REM_W'(1) : REM_W'(c.len_cyc);
      return cyc << 1;
   endfunction

   function automatic logic [RC_W-1:0] release_phases(input bank_cfg_t c);
      return RC_W'(c.rel_cyc) << 1;
   endfunction

endpackage

// File: rtl/memstrobe_cfg_sel.sv
`timescale 1ns/1ps
module memstrobe_cfg_sel
   import memstrobe_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2
) (
   input  logic [NUM_BANKS*CFG_W-1:0] cfg_flat,
   input  logic [BANK_W-1:0]          bank,
   output bank_cfg_t                  cfg
);

   localparam bit POW2 = ((1 << BANK_W) == NUM_BANKS);

   bank_cfg_t words [NUM_BANKS];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_BANKS; gi++) begin : g_unpack
         assign words[gi] = bank_cfg_t'(cfg_flat[gi*CFG_W +: CFG_W]);
      end

      if (POW2) begin : g_direct
         assign cfg = words[bank];
      end else begin : g_guarded
         always_comb begin
            cfg = words[0];
            for (int i = 1; i < NUM_BANKS; i++) begin
               if (bank == BANK_W'(i)) cfg = words[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/memstrobe_seq.sv
`timescale 1ns/1ps
module memstrobe_seq
   import memstrobe_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  bank_cfg_t         sel_cfg,
   input  logic              mem_wait,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              active,
   output bank_cfg_t         cur_cfg,
   output logic              cur_write,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_wdata,
   output logic [PCNT_W-1:0] phase,
   output logic [REM_W-1:0]  remain,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);

   localparam int LANES = DATA_W / 8;

   seq_state_t       st;
   logic             pend;
   logic [RC_W-1:0]  rel_cnt;
   logic             fire;
   logic             stall;
   bank_cfg_t        start_cfg;
   logic [DATA_W-1:0] lane_mask;

   assign fire      = req_valid & req_ready;
   assign req_ready = (st == ST_IDLE) || ((st == ST_RELEASE) && !pend);
   assign active    = (st == ST_ACCESS);
   assign stall     = cur_cfg.wait_en & mem_wait;
   assign start_cfg = fire ? sel_cfg : cur_cfg;

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_mask
         if (gl == 0) begin : g_low
            assign lane_mask[7:0] = 8'hFF;
         end else begin : g_high
            assign lane_mask[gl*8 +: 8] = {8{cur_cfg.wide}};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         pend      <= 1'b0;
         rel_cnt   <= '0;
         cur_cfg   <= '0;
         cur_write <= 1'b0;
         cur_addr  <= '0;
         cur_wdata <= '0;
         phase     <= '0;
         remain    <= '0;
         done      <= 1'b0;
         rdata     <= '0;
      end else begin
         done <= 1'b0;
         if (fire) begin
            cur_cfg   <= sel_cfg;
            cur_write <= req_write;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
         end
         case (st)
            ST_IDLE: begin
               if (fire) begin
                  st     <= ST_ACCESS;
                  phase  <= '0;
                  remain <= access_phases(sel_cfg);
               end
            end
            ST_ACCESS: begin
               if (phase != {PCNT_W{1'b1}}) phase <= phase + 1'b1;
               if (!stall) begin
                  if (remain == REM_W'(1)) begin
                     done  <= 1'b1;
                     rdata <= mem_dq_in & lane_mask;
                     if (cur_cfg.rel_cyc == 2'd0) begin
                        st <= ST_IDLE;
                     end else begin
                        st      <= ST_RELEASE;
                        rel_cnt <= release_phases(cur_cfg);
                     end
                  end else begin
                     remain <= remain - 1'b1;
                  end
               end
            end
            ST_RELEASE: begin
               if (fire) pend <= 1'b1;
               if (rel_cnt == RC_W'(1)) begin
                  if (fire || pend) begin
                     st     <= ST_ACCESS;
                     phase  <= '0;
                     remain <= access_phases(start_cfg);
                     pend   <= 1'b0;
                  end else begin
                     st <= ST_IDLE;
                  end
               end else begin
                  rel_cnt <= rel_cnt - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/memstrobe_decode.sv
`timescale 1ns/1ps
module memstrobe_decode
   import memstrobe_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic              active,
   input  logic              write,
   input  logic              wide,
   input  logic [3:0]        ce_fall,
   input  logic [3:0]        ce_lead,
   input  logic [3:0]        oe_fall,
   input  logic [3:0]        we_fall,
   input  logic [3:0]        we_lead,
   input  logic [3:0]        drv_dly,
   input  logic [PCNT_W-1:0] phase,
   input  logic [REM_W-1:0]  remain,
   output logic              ce_n,
   output logic              oe_n,
   output logic [LANES-1:0]  we_n,
   output logic              dq_oe
);

   logic ce_on, oe_on, we_on;

   assign ce_on = active && (phase >= PCNT_W'(ce_fall)) && (remain > REM_W'(ce_lead));
   assign oe_on = active && !write && (phase >= PCNT_W'(oe_fall));
   assign we_on = active && write && (phase >= PCNT_W'(we_fall)) && (remain > REM_W'(we_lead));

   assign ce_n  = !ce_on;
   assign oe_n  = !oe_on;
   assign dq_oe = active && write && (phase >= PCNT_W'(drv_dly));

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_lane
         if (gl == 0) begin : g_base
            assign we_n[gl] = !we_on;
         end else begin : g_upper
            assign we_n[gl] = !(we_on && wide);
         end
      end
   endgenerate

endmodule

// File: rtl/memstrobe_gen.sv
`timescale 1ns/1ps
module memstrobe_gen
   import memstrobe_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 16,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int LANES    = DATA_W / 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_BANKS*CFG_W-1:0] bank_cfg,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic [BANK_W-1:0]          req_bank,
   input  logic                       req_write,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [DATA_W-1:0]          req_wdata,
   output logic                       done,
   output logic [DATA_W-1:0]          rdata,
   output logic [ADDR_W-1:0]          mem_addr,
   output logic [DATA_W-1:0]          mem_dq_out,
   output logic                       mem_dq_oe,
   input  logic [DATA_W-1:0]          mem_dq_in,
   input  logic                       mem_wait,
   output logic                       mem_ce_n,
   output logic                       mem_oe_n,
   output logic [LANES-1:0]           mem_we_n
);

   initial begin
      assert (NUM_BANKS >= 1) else $error("NUM_BANKS must be at least 1");
      assert (DATA_W >= 16 && (DATA_W % 8) == 0) else $error("DATA_W must be a byte multiple of at least 16");
      assert (ADDR_W >= 1) else $error("ADDR_W must be positive");
   end

   bank_cfg_t         sel_cfg;
   bank_cfg_t         cur_cfg;
   logic              seq_active;
   logic              cur_write;
   logic              cur_wide;
   logic [PCNT_W-1:0] phase;
   logic [REM_W-1:0]  remain;

   memstrobe_cfg_sel #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) u_cfg_sel (
      .cfg_flat (bank_cfg),
      .bank     (req_bank),
      .cfg      (sel_cfg)
   );

   memstrobe_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .sel_cfg   (sel_cfg),
      .mem_wait  (mem_wait),
      .mem_dq_in (mem_dq_in),
      .active    (seq_active),
      .cur_cfg   (cur_cfg),
      .cur_write (cur_write),
      .cur_addr  (mem_addr),
      .cur_wdata (mem_dq_out),
      .phase     (phase),
      .remain    (remain),
      .done      (done),
      .rdata     (rdata)
   );

   assign cur_wide = cur_cfg.wide;

   memstrobe_decode #(
      .LANES (LANES)
   ) u_decode (
      .active  (seq_active),
      .write   (cur_write),
      .wide    (cur_wide),
      .ce_fall (cur_cfg.ce_fall),
      .ce_lead (cur_cfg.ce_lead),
      .oe_fall (cur_cfg.oe_fall),
      .we_fall (cur_cfg.we_fall),
      .we_lead (cur_cfg.we_lead),
      .drv_dly (cur_cfg.drv_dly),
      .phase   (phase),
      .remain  (remain),
      .ce_n    (mem_ce_n),
      .oe_n    (mem_oe_n),
      .we_n    (mem_we_n),
      .dq_oe   (mem_dq_oe)
   );

endmodule

// File: rtl/memstrobe_gen_checker.sv
`timescale 1ns/1ps
module memstrobe_gen_checker #(
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ce_n,
   input logic             oe_n,
   input logic [LANES-1:0] we_n,
   input logic             dq_oe,
   input logic             done,
   input logic             req_ready,
   input logic             active,
   input logic             cur_wide
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (ce_n && oe_n && (&we_n) && !dq_oe));

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(active));

   assert_rd_wr_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !(&we_n)));

   assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> oe_n);

   assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> !req_ready);

   assert_narrow_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !cur_wide) |-> (&we_n[LANES-1:1]));

endmodule

bind memstrobe_gen memstrobe_gen_checker #(.LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n      (mem_ce_n),
   .oe_n      (mem_oe_n),
   .we_n      (mem_we_n),
   .dq_oe     (mem_dq_oe),
   .done      (done),
   .req_ready (req_ready),
   .active    (seq_active),
   .cur_wide  (cur_wide)
);

// File: tb/memstrobe_gen_bench.sv
`timescale 1ns/1ps
module memstrobe_gen_bench;

   localparam int NB = 4;
   localparam int AW = 20;
   localparam int DW = 16;
   localparam logic [DW-1:0] DQ_IN = 16'hA55A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB*32-1:0] bank_cfg;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_bank = '0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          done;
   logic [DW-1:0] rdata;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_out;
   logic          mem_dq_oe;
   logic [DW-1:0] mem_dq_in = DQ_IN;
   logic          mem_wait = 1'b0;
   logic          mem_ce_n;
   logic          mem_oe_n;
   logic [1:0]    mem_we_n;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [63:0] ce_tr, oe_tr, we0_tr, we1_tr, dqoe_tr, done_tr, rdy_tr;

   always #2.5 clk = ~clk;

   memstrobe_gen #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) u_memstrobe_gen (
      .clk(clk), .rst_n(rst_n), .bank_cfg(bank_cfg),
      .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_wait(mem_wait),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
   );

   // R10: field positions of the configuration word
   function automatic logic [31:0] mk_cfg(int len, int rel, int wide, int wen, int cef,
                                          int cel, int oef, int wef, int wel, int drv);
      return (32'(len) & 32'hF) | ((32'(rel) & 32'h3) << 4) | ((32'(wide) & 32'h1) << 6)
           | ((32'(wen) & 32'h1) << 7) | ((32'(cef) & 32'hF) << 8) | ((32'(cel) & 32'hF) << 12)
           | ((32'(oef) & 32'hF) << 16) | ((32'(wef) & 32'hF) << 20) | ((32'(wel) & 32'hF) << 24)
           | ((32'(drv) & 32'hF) << 28);
   endfunction

   task automatic check_eq(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int first_idx(logic [63:0] tr, int from, logic v);
      for (int i = from; i < 64; i++) if (tr[i] == v) return i;
      return -1;
   endfunction

   task automatic run_trace(int bank, bit wr, int wdata, int ws, int wl,
                            int sec_at, int sec_bank, bit sec_wr);
      @(negedge clk);
      req_valid = 1'b1; req_bank = 2'(bank); req_write = wr;
      req_addr = 20'h1234 + AW'(bank); req_wdata = DW'(wdata);
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (i == 0 || i == sec_at + 1) req_valid = 1'b0;
         ce_tr[i] = mem_ce_n; oe_tr[i] = mem_oe_n;
         we0_tr[i] = mem_we_n[0]; we1_tr[i] = mem_we_n[1];
         dqoe_tr[i] = mem_dq_oe; done_tr[i] = done; rdy_tr[i] = req_ready;
         mem_wait = (i >= ws) && (i < ws + wl);
         if (i == sec_at) begin
            req_valid = 1'b1; req_bank = 2'(sec_bank); req_write = sec_wr;
         end
      end
      mem_wait = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check_eq("R1 ce_n idle", int'(mem_ce_n), 1);
      check_eq("R1 oe_n idle", int'(mem_oe_n), 1);
      check_eq("R1 we_n idle", int'(mem_we_n), 3);
      check_eq("R1 dq_oe idle", int'(mem_dq_oe), 0);
      check_eq("R1 done idle", int'(done), 0);
      check_eq("R1 ready idle", int'(req_ready), 1);
   endtask

   // bank 0: len 6 (12 phases), rel 1, wide, wait off, ce 1/2, oe 3, we 2/1, drv 1
   task automatic t_read_wide;
      run_trace(0, 1'b0, 0, -1, 0, -1, 0, 1'b0);
      check_eq("R3 read ce fall", first_idx(ce_tr, 0, 1'b0), 1);
      check_eq("R3 read ce rise", first_idx(ce_tr, 1, 1'b1), 10);
      check_eq("R4 read oe fall", first_idx(oe_tr, 0, 1'b0), 3);
      check_eq("R4 read oe rise", first_idx(oe_tr, 3, 1'b1), 12);
      check_eq("R5 read no we", first_idx(we0_tr, 0, 1'b0), -1);
      check_eq("R6 read no drive", first_idx(dqoe_tr, 0, 1'b1), -1);
      check_eq("R2 read done phase", first_idx(done_tr, 0, 1'b1), 12);
      check_eq("R2 done one clock", int'(done_tr[13]), 0);
      check_eq("R9 wide read data", int'(rdata), int'(DQ_IN));
      check_eq("R8 not ready in access", int'(rdy_tr[3]), 0);
      check_eq("R8 ready in release", int'(rdy_tr[12]), 1);
   endtask

   // bank 1: len 5 (10 phases), rel 0, wide, wait on, ce 0/1, oe 2, we 3/2, drv 2
   task automatic t_write_wide;
      run_trace(1, 1'b1, 16'hBEEF, -1, 0, -1, 0, 1'b0);
      check_eq("R3 write ce fall", first_idx(ce_tr, 0, 1'b0), 0);
      check_eq("R3 write ce rise", first_idx(ce_tr, 0, 1'b1), 9);
      check_eq("R5 write we0 fall", first_idx(we0_tr, 0, 1'b0), 3);
      check_eq("R5 write we0 rise", first_idx(we0_tr, 3, 1'b1), 8);
      check_eq("R9 wide we1 fall", first_idx(we1_tr, 0, 1'b0), 3);
      check_eq("R4 write oe high", first_idx(oe_tr, 0, 1'b0), -1);
      check_eq("R6 drive start", first_idx(dqoe_tr, 0, 1'b1), 2);
      check_eq("R6 drive stop", first_idx(dqoe_tr, 2, 1'b0), 10);
      check_eq("R6 write data", int'(mem_dq_out), 16'hBEEF);
      check_eq("R2 write done phase", first_idx(done_tr, 0, 1'b1), 10);
   endtask

   // bank 2: len 4 (8 phases), rel 2, narrow, wait off, ce 1/1, oe 1, we 2/1, drv 0
   task automatic t_narrow;
      run_trace(2, 1'b1, 16'h1234, -1, 0, -1, 0, 1'b0);
      check_eq("R9 narrow we0 fall", first_idx(we0_tr, 0, 1'b0), 2);
      check_eq("R5 narrow we0 rise", first_idx(we0_tr, 2, 1'b1), 7);
      check_eq("R9 narrow we1 held", first_idx(we1_tr, 0, 1'b0), -1);
      run_trace(2, 1'b0, 0, -1, 0, -1, 0, 1'b0);
      check_eq("R9 narrow read data", int'(rdata), 16'h005A);
   endtask

   task automatic t_wait_on;
      run_trace(1, 1'b1, 16'h0F0F, 4, 3, -1, 0, 1'b0);
      check_eq("R7 wait stretches done", first_idx(done_tr, 0, 1'b1), 13);
      check_eq("R7 wait moves we rise", first_idx(we0_tr, 3, 1'b1), 11);
      check_eq("R7 wait moves ce rise", first_idx(ce_tr, 0, 1'b1), 12);
   endtask

   task automatic t_wait_off;
      run_trace(0, 1'b0, 0, 4, 3, -1, 0, 1'b0);
      check_eq("R7 wait ignored done", first_idx(done_tr, 0, 1'b1), 12);
      check_eq("R7 wait ignored ce rise", first_idx(ce_tr, 1, 1'b1), 10);
   endtask

   task automatic t_release;
      run_trace(2, 1'b0, 0, -1, 0, 8, 2, 1'b0);
      check_eq("R8 ready at release start", int'(rdy_tr[8]), 1);
      check_eq("R8 held request blocks ready", int'(rdy_tr[9]), 0);
      check_eq("R8 second ce fall after release", first_idx(ce_tr, 8, 1'b0), 13);
      check_eq("R8 second done", first_idx(done_tr, 9, 1'b1), 20);
      run_trace(1, 1'b1, 16'h5555, -1, 0, 10, 1, 1'b1);
      check_eq("R8 zero release start", first_idx(ce_tr, 9, 1'b0), 11);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bank_cfg[31:0]   = mk_cfg(6, 1, 1, 0, 1, 2, 3, 2, 1, 1);
      bank_cfg[63:32]  = mk_cfg(5, 0, 1, 1, 0, 1, 2, 3, 2, 2);
      bank_cfg[95:64]  = mk_cfg(4, 2, 0, 0, 1, 1, 1, 2, 1, 0);
      bank_cfg[127:96] = mk_cfg(3, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read_wide();
      t_write_wide();
      t_narrow();
      t_wait_on();
      t_wait_off();
      t_release();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule